// File: doc/BRIEF.md
# I/O-Port Windowed RAM Bridge

This block gives a Z80-style host access to an 8 KB static RAM through I/O cycles only; the RAM never appears in memory space. A host I/O write or read whose upper address byte is 0xFC or 0xFD reaches one RAM byte. The low address byte and address bit 8 (the bit that separates 0xFC from 0xFD) select the byte inside a 512-byte window. A 4-bit page register supplies the top of the 13-bit RAM address. The host loads it by writing to port 0xFE.

The address and the data lines are wired to the RAM through fixed bit permutations. Writes scatter the bits onto the RAM pins and reads gather them back, so a byte written at a given port and page reads back unchanged. A data-bus output enable is raised only while a decoded data-port read is in progress. At all other times the bus is released. Strobes are single-cycle and synchronous to `clk`. RAM controls are combinational from the strobes, and the page register updates on the clock edge that ends a page write.

Top module: `iowin_ram_bridge`

## Requirements
- R1: During `io_wr` with `io_addr[15:9]` = 7'b1111110 (ports 0xFC/0xFD), `ram_we` is 1 in the same cycle. `ram_addr` is the permuted form of the logical address {page, io_addr[8], io_addr[7:0]}. `ram_wdata` is the permuted form of `host_din`.
- R2: During `io_rd` (without `io_wr`) to ports 0xFC/0xFD, `ram_oe` and `host_oe` are 1, `ram_we` is 0, and `host_dout` is the inverse-permuted form of `ram_rdata`.
- R3: `io_wr` with `io_addr[15:8]` = 0xFE loads `host_din[3:0]` into the page register at the clock edge; `host_din[7:4]` is ignored.
- R4: After reset the page register is 0.
- R5: `host_oe` and `ram_oe` are 1 only during a decoded data-port read. Reads of port 0xFE or of any other port leave them at 0, and `host_dout` is 0 whenever `host_oe` is 0.
- R6: Writes to any port other than 0xFC, 0xFD or 0xFE leave `ram_we` at 0 and the page register unchanged.
- R7: Address permutation: logical address bit j drives `ram_addr[(5*j+2) mod 13]`. Data permutation: logical data bit i drives `ram_wdata[(3*i+1) mod 8]`. On read, `host_dout[i]` = `ram_rdata[(3*i+1) mod 8]`.
- R8: Every one of the 8192 logical addresses (16 pages x 512 bytes) reaches a distinct RAM location, and a write followed by a read at the same port and page returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe, one cycle |
| host_din | input | 8 | Write data from the host bus |
| host_dout | output | 8 | Read data to the host bus |
| host_oe | output | 1 | Host data bus drive enable |
| ram_addr | output | 13 | RAM address pins (permuted) |
| ram_wdata | output | 8 | RAM write data pins (permuted) |
| ram_rdata | input | 8 | RAM read data pins (permuted) |
| ram_we | output | 1 | RAM write enable |
| ram_oe | output | 1 | RAM output enable |

## Verification
The bench fills all 8192 logical addresses through the ports and then reads every one back. A permutation that is not a bijection, or an address bit taken from the wrong place, would alias two locations and return the wrong byte. Single writes compare the RAM pins against arithmetically permuted values, which catches a design that permutes the bits correctly but in the wrong direction. Page writes carry junk in the upper nibble, which catches a register that is wider than four bits. Reads of port 0xFE, and writes to near-miss ports such as 0xFB and 0x7C, check that the design neither drives the bus nor corrupts the RAM or the page.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
    localparam int DATA_W     = 8;
    localparam int PAGE_W     = 4;
    localparam int WIN_W      = 9;
    localparam int RAM_ADDR_W = PAGE_W + WIN_W;

    // upper 7 address bits shared by the two data ports
    localparam logic [6:0] DATA_PORT_HI = 7'b1111110;
    localparam logic [7:0] PAGE_PORT    = 8'hFE;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } iowin_state_t;
endpackage

// File: rtl/iowin_port_decode.sv
module iowin_port_decode
    import iowin_pkg::*;
(
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    output logic        data_wr,
    output logic        data_rd,
    output logic        page_wr
);
    logic data_hit;
    logic page_hit;

    always_comb begin
        data_hit = (io_addr[15:9] == DATA_PORT_HI);
        page_hit = (io_addr[15:8] == PAGE_PORT);
        data_wr  = io_wr & data_hit;
        data_rd  = io_rd & ~io_wr & data_hit;
        page_wr  = io_wr & page_hit;
    end
endmodule

// File: rtl/iowin_bit_perm.sv
module iowin_bit_perm #(
    parameter int W       = 8,
    parameter int STRIDE  = 3,
    parameter int SHIFT   = 1,
    parameter bit SCATTER = 1'b1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int J = (i * STRIDE + SHIFT) % W;
        if (SCATTER) begin : g_sc
            assign dout[J] = din[i];
        end else begin : g_ga
            assign dout[i] = din[J];
        end
    end
endmodule

// File: rtl/iowin_ram_bridge.sv
module iowin_ram_bridge
    import iowin_pkg::*;
#(
    parameter int ADDR_STRIDE = 5,
    parameter int ADDR_SHIFT  = 2,
    parameter int DATA_STRIDE = 3,
    parameter int DATA_SHIFT  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [DATA_W-1:0]     host_din,
    output logic [DATA_W-1:0]     host_dout,
    output logic                  host_oe,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0]     ram_wdata,
    input  logic [DATA_W-1:0]     ram_rdata,
    output logic                  ram_we,
    output logic                  ram_oe
);
    iowin_state_t st_d, st_q;
    logic data_wr, data_rd, page_wr;
    logic [RAM_ADDR_W-1:0] log_addr;
    logic [DATA_W-1:0]     rd_gather;

    iowin_port_decode u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .page_wr (page_wr)
    );

    always_comb begin
        st_d = st_q;
        if (page_wr) st_d.page = host_din[PAGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign log_addr = {st_q.page, io_addr[WIN_W-1:0]};

    iowin_bit_perm #(.W(RAM_ADDR_W), .STRIDE(ADDR_STRIDE), .SHIFT(ADDR_SHIFT), .SCATTER(1'b1)) u_aperm (
        .din  (log_addr),
        .dout (ram_addr)
    );

    iowin_bit_perm #(.W(DATA_W), .STRIDE(DATA_STRIDE), .SHIFT(DATA_SHIFT), .SCATTER(1'b1)) u_wperm (
        .din  (host_din),
        .dout (ram_wdata)
    );

    iowin_bit_perm #(.W(DATA_W), .STRIDE(DATA_STRIDE), .SHIFT(DATA_SHIFT), .SCATTER(1'b0)) u_rperm (
        .din  (ram_rdata),
        .dout (rd_gather)
    );

    always_comb begin
        ram_we    = data_wr;
        ram_oe    = data_rd;
        host_oe   = data_rd;
        host_dout = data_rd ? rd_gather : '0;
    end
endmodule

// File: rtl/iowin_ram_bridge_chk.sv
module iowin_ram_bridge_chk
    import iowin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [DATA_W-1:0] host_din,
    input logic [DATA_W-1:0] host_dout,
    input logic              host_oe,
    input logic              ram_we,
    input logic              ram_oe,
    input logic [PAGE_W-1:0] page
);
    // R1
    we_needs_data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (io_wr && io_addr[15:9] == DATA_PORT_HI));
    // R2
    no_we_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr) |-> !ram_we);
    // R3
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[15:8] == PAGE_PORT) |=> (page == $past(host_din[PAGE_W-1:0])));
    // R6
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr[15:8] == PAGE_PORT) |=> $stable(page));
    // R5
    oe_only_data_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_oe || ram_oe) |-> (io_rd && io_addr[15:9] == DATA_PORT_HI));
    // R5
    released_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_oe |-> (host_dout == '0));
endmodule

bind iowin_ram_bridge iowin_ram_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .host_din  (host_din),
    .host_dout (host_dout),
    .host_oe   (host_oe),
    .ram_we    (ram_we),
    .ram_oe    (ram_oe),
    .page      (st_q.page)
);

// File: tb/tb_iowin_ram_bridge.sv
module tb_iowin_ram_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        host_oe;
    logic [12:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic        ram_we;
    logic        ram_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mem [8192];

    always #5 clk = ~clk;

    iowin_ram_bridge dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .host_din(host_din), .host_dout(host_dout), .host_oe(host_oe),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_oe(ram_oe)
    );

    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
    assign ram_rdata = mem[ram_addr];

    function automatic logic [12:0] pa(input logic [12:0] l);
        logic [12:0] r = '0;
        for (int j = 0; j < 13; j++) r[(5*j+2)%13] = l[j];
        return r;
    endfunction

    function automatic logic [7:0] pd(input logic [7:0] l);
        logic [7:0] r = '0;
        for (int i = 0; i < 8; i++) r[(3*i+1)%8] = l[i];
        return r;
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; host_din = d; io_wr = 1'b1; io_rd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #1;
        d = host_dout; oe = host_oe;
        @(posedge clk);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        logic       oe;
        for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R4 and R1: reset page is 0, pins carry permuted address and data
        @(negedge clk);
        io_addr = 16'hFC05; host_din = 8'hC3; io_wr = 1'b1;
        #1;
        chk("R4", ram_addr, pa(13'h005));
        chk("R1", ram_we, 1);
        chk("R7", ram_wdata, pd(8'hC3));
        chk("R5", host_oe, 0);
        @(posedge clk); @(negedge clk); io_wr = 1'b0;

        // R1/R3: page with junk upper nibble, check pin address on 0xFD
        io_write(16'hFE00, 8'hA9);
        @(negedge clk);
        io_addr = 16'hFD7E; host_din = 8'h01; io_wr = 1'b1;
        #1;
        chk("R3", ram_addr, pa({4'h9, 1'b1, 8'h7E}));
        chk("R1", ram_wdata, pd(8'h01));
        @(posedge clk); @(negedge clk); io_wr = 1'b0;

        // R2/R7: read pins gathered back
        @(negedge clk);
        io_addr = 16'hFD7E; io_rd = 1'b1;
        #1;
        chk("R2", host_oe, 1);
        chk("R2", ram_oe, 1);
        chk("R2", ram_we, 0);
        chk("R7", host_dout, 8'h01);
        @(posedge clk); @(negedge clk); io_rd = 1'b0;

        // R8: fill all 8192 addresses, then read all back
        for (int p = 0; p < 16; p++) begin
            io_write(16'hFE00, {4'h6, 4'(p)});
            for (int w = 0; w < 512; w++)
                io_write({7'b1111110, 9'(w)}, pat(p * 512 + w));
        end
        for (int p = 0; p < 16; p++) begin
            io_write(16'hFE00, {4'hF, 4'(p)});
            for (int w = 0; w < 512; w++) begin
                io_read({7'b1111110, 9'(w)}, rd, oe);
                chk("R8", rd, pat(p * 512 + w));
            end
        end

        // R5: reads of page port and unrelated port leave bus released
        io_read(16'hFE00, rd, oe);
        chk("R5", oe, 0);
        chk("R5", rd, 0);
        io_read(16'h1234, rd, oe);
        chk("R5", oe, 0);
        chk("R5", rd, 0);
        chk("R5", ram_oe, 0);

        // R6: near-miss port writes do nothing; page still 15
        @(negedge clk);
        io_addr = 16'h7C03; host_din = 8'hFF; io_wr = 1'b1;
        #1; chk("R6", ram_we, 0);
        @(posedge clk); @(negedge clk); io_wr = 1'b0;
        io_write(16'hFB03, 8'h02);
        io_write(16'hFF03, 8'h02);
        io_read(16'hFC03, rd, oe);
        chk("R6", rd, pat(15 * 512 + 3));

        // R3: switching page selects other contents
        io_write(16'hFE00, 8'hF2);
        io_read(16'hFD10, rd, oe);
        chk("R3", rd, pat(2 * 512 + 256 + 16));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule